// File: doc/BRIEF.md
# DMA Address Translation Page Walker

This block turns a device DMA request into a series of physical-memory transfer commands. A request is a 32-bit device virtual address, a byte count and a direction flag. The walker handles it one 4 KB page at a time. For each page it reads one 32-bit page-table entry through a memory read port. The entry's location comes from a table base value and a window-start mask, both supplied by the surrounding register block. The walker then checks the entry's permission bits, builds a 36-bit physical address and issues one transfer command that never crosses the page boundary.

A bad entry ends the whole request. No command is issued for the offending page or for any page after it. Instead the walker pulses a fault capture that carries an error status word and the page-aligned virtual address, which the register block latches and uses to raise its interrupt. A normal end is marked by a one-cycle completion pulse. Only commands are produced here; the data itself moves elsewhere.

Top module: `dma_xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `pte_rd_valid`, `xfer_valid`, `done_pulse` and `fault_pulse` are all 0.
- R2: A request is taken only while the walker is idle (`req_ready` high). While a request is in progress, `req_ready` stays low and any `req_valid` with other address, length or direction has no effect on the commands issued.
- R3: A request of length 0 gives `done_pulse` in the cycle after acceptance, with no entry read and no transfer command.
- R4: The entry read address is (`cfg_pt_base` << 4) + (((page address AND NOT `cfg_win_start`) >> 10) AND NOT 3), computed over 36 bits. The page address is the current virtual address with its low 12 bits cleared.
- R5: Each transfer length is the smaller of the remaining byte count and 4096 minus the current address bits [11:0]. A request is split at every 4 KB boundary.
- R6: The transfer physical address is entry bits [31:8] placed at address bits [35:12], concatenated with virtual address bits [11:0]. Entry bits [7:3] and [0] have no effect.
- R7: An entry with bit 1 (valid) clear ends the request with a fault. No transfer is issued for that page or any later page.
- R8: A write through an entry with bit 2 (writable) clear ends the request with a fault. A read through such an entry proceeds normally.
- R9: On a fault, `fault_status` is 0xC0820000 for a write and 0xC0860000 for a read, and `fault_page` is the virtual address of the failing page with bits [11:0] zero. Both are valid during the `fault_pulse` cycle.
- R10: `done_pulse` is one cycle long and follows the last transfer handshake. It never occurs together with `fault_pulse`.
- R11: Once `pte_rd_valid` or `xfer_valid` is raised, it stays high with a stable payload until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Device virtual start address |
| req_len | input | 16 | Byte count |
| req_write | input | 1 | 1 = write to memory, 0 = read |
| cfg_pt_base | input | 32 | Page-table base value (shifted left by 4) |
| cfg_win_start | input | 32 | Window start mask; its set bits are removed from the index |
| pte_rd_valid | output | 1 | Entry read request |
| pte_rd_ready | input | 1 | Entry read request taken |
| pte_rd_addr | output | 36 | Physical address of the entry |
| pte_rsp_valid | input | 1 | Entry data returned |
| pte_rsp_data | input | 32 | Entry contents |
| xfer_valid | output | 1 | Transfer command present |
| xfer_ready | input | 1 | Transfer command taken |
| xfer_paddr | output | 36 | Physical start address of the chunk |
| xfer_len | output | 13 | Chunk length in bytes (1 to 4096) |
| xfer_write | output | 1 | Direction of the chunk |
| done_pulse | output | 1 | One-cycle completion marker |
| fault_pulse | output | 1 | One-cycle fault capture strobe |
| fault_status | output | 32 | Error status word for the capture |
| fault_page | output | 32 | Page-aligned virtual address of the fault |

## Verification
Two events can meet in a single cycle. A new `req_valid` can be presented while the previous walk is ending. A backpressured command can also coincide with a request still pending at the input, which happens when every request of a sweep is run with `req_valid` held high and alternative fields driven for the whole walk. The commands are then judged against the model of the first request only, `req_ready` is sampled low right after acceptance, and the input is withdrawn in the same cycle that `done_pulse` or `fault_pulse` is seen, so a stray second acceptance would show up as an unexpected read. Stalls of zero to two cycles on both ready inputs combine command hold with entry-read hold across page boundaries, and each held cycle is compared again.

// File: rtl/xw_pkg.sv
package xw_pkg;

   typedef enum logic [2:0] {
      W_IDLE,
      W_FETCH,
      W_WAIT,
      W_ISSUE,
      W_NEXT,
      W_DONE,
      W_FAULT
   } walk_st_t;

   // entry permission bit positions
   localparam int PTE_VALID_BIT = 1;
   localparam int PTE_WR_BIT    = 2;

   // fault status fields
   localparam logic [31:0] FLT_ANY    = 32'h8000_0000;
   localparam logic [31:0] FLT_LATE   = 32'h4000_0000;
   localparam logic [31:0] FLT_FIXED  = 32'h0080_0000;
   localparam logic [31:0] FLT_ADRVAL = 32'h0002_0000;
   localparam logic [31:0] FLT_READ   = 32'h0004_0000;
   localparam logic [31:0] FLT_BASE   = FLT_ANY | FLT_LATE | FLT_FIXED | FLT_ADRVAL;

endpackage

// File: rtl/xw_chunk.sv
module xw_chunk #(
   parameter int PAGE_SHIFT = 12,
   parameter int LEN_W      = 16
) (
   input  logic [PAGE_SHIFT-1:0] offset,
   input  logic [LEN_W-1:0]      remain,
   output logic [PAGE_SHIFT:0]   chunk,
   output logic                  last
);
   localparam int CHUNK_W = PAGE_SHIFT + 1;
   localparam int CMP_W   = (LEN_W > CHUNK_W) ? LEN_W : CHUNK_W;

   generate
      if (PAGE_SHIFT < 2) begin : g_bad_page
         $error("xw_chunk: PAGE_SHIFT too small");
      end
   endgenerate

   logic [CHUNK_W-1:0] room;
   logic [CMP_W-1:0]   rem_x;
   logic [CMP_W-1:0]   room_x;

   always_comb begin
      room   = (CHUNK_W'(1) << PAGE_SHIFT) - CHUNK_W'(offset);
      rem_x  = CMP_W'(remain);
      room_x = CMP_W'(room);
      last   = (rem_x <= room_x);
      chunk  = last ? rem_x[CHUNK_W-1:0] : room;
   end

endmodule

// File: rtl/xw_pte_addr.sv
module xw_pte_addr #(
   parameter int VA_W       = 32,
   parameter int PA_W       = 36,
   parameter int PAGE_SHIFT = 12,
   parameter int ENT_LOG2   = 2,
   parameter int BASE_SHIFT = 4
) (
   input  logic [VA_W-1:0] base,
   input  logic [VA_W-1:0] win,
   input  logic [VA_W-1:0] vaddr,
   output logic [VA_W-1:0] page_va,
   output logic [PA_W-1:0] pte_addr
);
   localparam int IDX_SHIFT = PAGE_SHIFT - ENT_LOG2;

   generate
      if (PA_W < VA_W + BASE_SHIFT) begin : g_bad_pa
         $error("xw_pte_addr: PA_W cannot hold the shifted base");
      end
      if (IDX_SHIFT < 1) begin : g_bad_idx
         $error("xw_pte_addr: entry size larger than page");
      end
   endgenerate

   logic [VA_W-1:0] idx;
   logic [PA_W-1:0] base_sh;
   logic [PA_W-1:0] offs;
   logic            unused_low;

   always_comb begin
      page_va = {vaddr[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
      idx     = page_va & ~win;
      base_sh = PA_W'(base) << BASE_SHIFT;
      // page_va has zero low bits, so the shifted index is already entry aligned
      offs    = PA_W'(idx >> IDX_SHIFT);
      pte_addr = base_sh + offs;
   end

   assign unused_low = ^vaddr[PAGE_SHIFT-1:0];

endmodule

// File: rtl/xw_pte_check.sv
module xw_pte_check
   import xw_pkg::*;
#(
   parameter int PTE_W      = 32,
   parameter int PA_W       = 36,
   parameter int PAGE_SHIFT = 12,
   parameter int PFN_LSB    = 8
) (
   input  logic [PTE_W-1:0]      pte,
   input  logic [PAGE_SHIFT-1:0] offset,
   input  logic                  is_write,
   output logic                  ok,
   output logic [PA_W-1:0]       paddr
);
   generate
      if ((PTE_W - PFN_LSB) + PAGE_SHIFT != PA_W) begin : g_bad_pfn
         $error("xw_pte_check: frame field does not fill PA_W");
      end
      if (PFN_LSB <= PTE_WR_BIT) begin : g_bad_lsb
         $error("xw_pte_check: frame field overlaps flag bits");
      end
   endgenerate

   logic unused_flags;

   always_comb begin
      ok    = pte[PTE_VALID_BIT] && (!is_write || pte[PTE_WR_BIT]);
      paddr = {pte[PTE_W-1:PFN_LSB], offset};
   end

   assign unused_flags = ^pte[PFN_LSB-1:0];

endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
   import xw_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PA_W       = 36,
   parameter int LEN_W      = 16,
   parameter int PAGE_SHIFT = 12,
   parameter int PTE_W      = 32,
   parameter int PFN_LSB    = 8,
   parameter int BASE_SHIFT = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [VA_W-1:0]       req_vaddr,
   input  logic [LEN_W-1:0]      req_len,
   input  logic                  req_write,
   input  logic [VA_W-1:0]       cfg_pt_base,
   input  logic [VA_W-1:0]       cfg_win_start,
   output logic                  pte_rd_valid,
   input  logic                  pte_rd_ready,
   output logic [PA_W-1:0]       pte_rd_addr,
   input  logic                  pte_rsp_valid,
   input  logic [PTE_W-1:0]      pte_rsp_data,
   output logic                  xfer_valid,
   input  logic                  xfer_ready,
   output logic [PA_W-1:0]       xfer_paddr,
   output logic [PAGE_SHIFT:0]   xfer_len,
   output logic                  xfer_write,
   output logic                  done_pulse,
   output logic                  fault_pulse,
   output logic [31:0]           fault_status,
   output logic [VA_W-1:0]       fault_page
);
   localparam int CHUNK_W = PAGE_SHIFT + 1;

   generate
      if (VA_W <= PAGE_SHIFT) begin : g_bad_va
         $error("dma_xlate_walker: VA_W must exceed PAGE_SHIFT");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("dma_xlate_walker: LEN_W must be positive");
      end
   endgenerate

   walk_st_t           st;
   logic [VA_W-1:0]    cur_va;
   logic [LEN_W-1:0]   rem;
   logic               wr_q;
   logic [PTE_W-1:0]   pte_q;
   logic [31:0]        flt_status_q;
   logic [VA_W-1:0]    flt_page_q;

   logic [VA_W-1:0]    page_va;
   logic [CHUNK_W-1:0] chunk;
   logic               last;
   logic [PTE_W-1:0]   chk_pte;
   logic               chk_ok;

   // entry location for the current page
   xw_pte_addr #(
      .VA_W      (VA_W),
      .PA_W      (PA_W),
      .PAGE_SHIFT(PAGE_SHIFT),
      .ENT_LOG2  (2),
      .BASE_SHIFT(BASE_SHIFT)
   ) u_addr (
      .base    (cfg_pt_base),
      .win     (cfg_win_start),
      .vaddr   (cur_va),
      .page_va (page_va),
      .pte_addr(pte_rd_addr)
   );

   // page-bounded chunk length
   xw_chunk #(
      .PAGE_SHIFT(PAGE_SHIFT),
      .LEN_W     (LEN_W)
   ) u_chunk (
      .offset(cur_va[PAGE_SHIFT-1:0]),
      .remain(rem),
      .chunk (chunk),
      .last  (last)
   );

   // judge the arriving entry in WAIT, the held one afterwards
   assign chk_pte = (st == W_WAIT) ? pte_rsp_data : pte_q;

   xw_pte_check #(
      .PTE_W     (PTE_W),
      .PA_W      (PA_W),
      .PAGE_SHIFT(PAGE_SHIFT),
      .PFN_LSB   (PFN_LSB)
   ) u_check (
      .pte     (chk_pte),
      .offset  (cur_va[PAGE_SHIFT-1:0]),
      .is_write(wr_q),
      .ok      (chk_ok),
      .paddr   (xfer_paddr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= W_IDLE;
         cur_va       <= '0;
         rem          <= '0;
         wr_q         <= 1'b0;
         pte_q        <= '0;
         flt_status_q <= '0;
         flt_page_q   <= '0;
      end else begin
         case (st)
            W_IDLE: begin
               if (req_valid) begin
                  cur_va <= req_vaddr;
                  rem    <= req_len;
                  wr_q   <= req_write;
                  st     <= (req_len == '0) ? W_DONE : W_FETCH;
               end
            end
            W_FETCH: begin
               if (pte_rd_ready) st <= W_WAIT;
            end
            W_WAIT: begin
               if (pte_rsp_valid) begin
                  pte_q <= pte_rsp_data;
                  if (chk_ok) begin
                     st <= W_ISSUE;
                  end else begin
                     st           <= W_FAULT;
                     flt_status_q <= FLT_BASE | (wr_q ? 32'h0 : FLT_READ);
                     flt_page_q   <= page_va;
                  end
               end
            end
            W_ISSUE: begin
               if (xfer_ready) st <= W_NEXT;
            end
            W_NEXT: begin
               cur_va <= cur_va + VA_W'(chunk);
               rem    <= rem - LEN_W'(chunk);
               st     <= last ? W_DONE : W_FETCH;
            end
            W_DONE:  st <= W_IDLE;
            W_FAULT: st <= W_IDLE;
            default: st <= W_IDLE;
         endcase
      end
   end

   assign req_ready    = (st == W_IDLE);
   assign pte_rd_valid = (st == W_FETCH);
   assign xfer_valid   = (st == W_ISSUE);
   assign xfer_len     = chunk;
   assign xfer_write   = wr_q;
   assign done_pulse   = (st == W_DONE);
   assign fault_pulse  = (st == W_FAULT);
   assign fault_status = flt_status_q;
   assign fault_page   = flt_page_q;

   // ---------------- assertions ----------------
   assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_zero_len_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_len == '0) |=> (done_pulse && !pte_rd_valid));

   assert_chunk_in_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> ((xfer_len != '0) &&
         ((32'(xfer_paddr[PAGE_SHIFT-1:0]) + 32'(xfer_len)) <= (32'd1 << PAGE_SHIFT))));

   assert_fault_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse |-> (fault_status[31] && fault_page[PAGE_SHIFT-1:0] == '0));

   assert_end_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_pulse && fault_pulse));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);

   assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pte_rd_valid && !pte_rd_ready) |=> (pte_rd_valid && $stable(pte_rd_addr)));

   assert_xfer_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !xfer_ready) |=>
         (xfer_valid && $stable(xfer_paddr) && $stable(xfer_len)));

endmodule

// File: tb/tb_dma_xlate_walker.sv
`timescale 1ns/1ps
module tb_dma_xlate_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [15:0] req_len = '0;
   logic        req_write = 1'b0;
   logic [31:0] cfg_pt_base = '0;
   logic [31:0] cfg_win_start = '0;
   logic        pte_rd_valid;
   logic        pte_rd_ready = 1'b0;
   logic [35:0] pte_rd_addr;
   logic        pte_rsp_valid = 1'b0;
   logic [31:0] pte_rsp_data = '0;
   logic        xfer_valid;
   logic        xfer_ready = 1'b0;
   logic [35:0] xfer_paddr;
   logic [12:0] xfer_len;
   logic        xfer_write;
   logic        done_pulse;
   logic        fault_pulse;
   logic [31:0] fault_status;
   logic [31:0] fault_page;

   int nvec = 0;
   int nfail = 0;

   always #2.5 clk = ~clk;

   dma_xlate_walker dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_len(req_len), .req_write(req_write),
      .cfg_pt_base(cfg_pt_base), .cfg_win_start(cfg_win_start),
      .pte_rd_valid(pte_rd_valid), .pte_rd_ready(pte_rd_ready), .pte_rd_addr(pte_rd_addr),
      .pte_rsp_valid(pte_rsp_valid), .pte_rsp_data(pte_rsp_data),
      .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_paddr(xfer_paddr),
      .xfer_len(xfer_len), .xfer_write(xfer_write),
      .done_pulse(done_pulse), .fault_pulse(fault_pulse),
      .fault_status(fault_status), .fault_page(fault_page)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] make_pte(input logic [35:0] ea, input int kind);
      logic [7:0] fl;
      fl = (kind == 1) ? 8'hFD : (kind == 2) ? 8'hFB : 8'h87;
      return {ea[27:4] ^ 24'hA5C3E1, fl};
   endfunction

   task automatic run_req(input logic [31:0] va, input int len, input bit wr,
                          input int bad_pg, input int bad_kind, input int stall, input bit noise);
      logic [31:0] cur;
      logic [35:0] ea;
      logic [31:0] pte_e;
      int rem, pg, cyc, st_m, st_x, nrd, exp_len, kind;
      bit fin, rsp_due, req_hs, exp_flt;
      cur = va; rem = len; pg = 0; cyc = 0; nrd = 0; kind = 0;
      fin = 0; rsp_due = 0; req_hs = 0; exp_flt = 0; pte_e = '0;
      st_m = stall; st_x = stall;
      @(negedge clk);
      chk(req_ready == 1'b1, "R2 idle ready", 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_vaddr = va; req_len = 16'(len); req_write = wr;
      @(negedge clk);
      chk(req_ready == 1'b0, "R2 busy after accept", 64'(req_ready), 64'd0);
      req_valid = noise;
      req_vaddr = va ^ 32'h0055_5000; req_len = 16'd77; req_write = !wr;
      while (!fin) begin
         if (done_pulse) begin
            chk(!exp_flt && rem == 0, "R10 done after last chunk", 64'(rem), 64'd0);
            chk(!fault_pulse, "R10 done/fault exclusive", 64'(fault_pulse), 64'd0);
            if (len == 0) chk(nrd == 0, "R3 zero length no read", 64'(nrd), 64'd0);
            fin = 1;
         end else if (fault_pulse) begin
            chk(exp_flt, (bad_kind == 1) ? "R7 invalid entry fault" : "R8 write protect fault",
                64'(exp_flt), 64'd1);
            chk(fault_status == (wr ? 32'hC082_0000 : 32'hC086_0000), "R9 fault status",
                64'(fault_status), 64'(wr ? 32'hC082_0000 : 32'hC086_0000));
            chk(fault_page == {cur[31:12], 12'h000}, "R9 fault page",
                64'(fault_page), 64'({cur[31:12], 12'h000}));
            fin = 1;
         end else begin
            if (pte_rd_valid) begin
               ea = ({4'h0, cfg_pt_base} << 4) +
                    (({4'h0, {cur[31:12], 12'h000} & ~cfg_win_start}) >> 10);
               chk(pte_rd_addr == ea, (st_m != stall) ? "R11 read addr hold" : "R4 entry addr",
                   64'(pte_rd_addr), 64'(ea));
               if (st_m > 0) st_m--;
               else begin pte_rd_ready = 1'b1; req_hs = 1; st_m = stall; end
            end
            if (xfer_valid) begin
               exp_len = 4096 - int'(cur[11:0]);
               if (rem < exp_len) exp_len = rem;
               chk(!exp_flt, "R7 no transfer on bad page", 64'(xfer_valid), 64'd0);
               chk(xfer_paddr == {pte_e[31:8], cur[11:0]},
                   (st_x != stall) ? "R11 xfer hold" : "R6 physical address",
                   64'(xfer_paddr), 64'({pte_e[31:8], cur[11:0]}));
               chk(xfer_len == 13'(exp_len), "R5 chunk length", 64'(xfer_len), 64'(exp_len));
               chk(xfer_write == wr, "R8 direction", 64'(xfer_write), 64'(wr));
               if (st_x > 0) st_x--;
               else begin
                  xfer_ready = 1'b1; st_x = stall;
                  cur = cur + 32'(exp_len); rem = rem - exp_len; pg++;
               end
            end
         end
         if (!fin) begin
            @(negedge clk);
            cyc++;
            pte_rd_ready = 1'b0; xfer_ready = 1'b0; pte_rsp_valid = 1'b0;
            if (rsp_due) begin
               pte_rsp_valid = 1'b1; pte_rsp_data = pte_e; rsp_due = 0;
            end
            if (req_hs) begin
               req_hs = 0; rsp_due = 1; nrd++;
               kind = (pg == bad_pg) ? bad_kind : 0;
               pte_e = make_pte(ea, kind);
               exp_flt = (kind == 1) || (kind == 2 && wr);
            end
            if (cyc > 600) begin
               chk(1'b0, "R10 request never ended", 64'(cyc), 64'd600);
               fin = 1;
            end
         end
      end
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      int offs [5] = '{0, 1, 12'h800, 12'hFFC, 12'hFFF};
      int lens [6] = '{0, 1, 7, 4096, 5000, 9000};
      logic [31:0] vbase;
      int n;
      n = 0;
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
      chk({pte_rd_valid, xfer_valid, done_pulse, fault_pulse} == 4'b0000, "R1 reset outputs",
          64'({pte_rd_valid, xfer_valid, done_pulse, fault_pulse}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && !pte_rd_valid && !xfer_valid, "R1 after reset release",
          64'(req_ready), 64'd1);
      for (int c = 0; c < 2; c++) begin
         cfg_pt_base   = (c == 0) ? 32'h0012_3400 : 32'h07FF_FC00;
         cfg_win_start = (c == 0) ? 32'hFF00_0000 : 32'hC000_0000;
         vbase         = (c == 0) ? 32'hFF2A_7000 : 32'hD123_4000;
         for (int o = 0; o < 5; o++) begin
            for (int l = 0; l < 6; l++) begin
               for (int w = 0; w < 2; w++) begin
                  run_req(vbase + 32'(offs[o]), lens[l], w[0], -1, 0, n % 3, n[0]);
                  n++;
               end
            end
         end
         for (int bp = 0; bp < 3; bp++) begin
            for (int k = 1; k < 3; k++) begin
               for (int w = 0; w < 2; w++) begin
                  run_req(vbase + 32'h0000_0FF0, 9000, w[0], bp, k, bp % 2, 1'b1);
               end
            end
         end
      end
      repeat (3) @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule